// File: doc/BRIEF.md
# NAND Page Layout Sequencer

This block produces, one physical byte position at a time, the routing schedule that places a logical NAND page onto the flash array. The logical side has two sources: a data buffer of the page size and a spare area. The spare area holds a 6-byte bad-block marker, then 4 metadata bytes, then the ECC bytes of every packet in packet order. On the physical side, the page begins with the metadata. Each packet's data follows, with that packet's ECC bytes directly after it. The marker window sits at the physical offset equal to the page size, so it falls inside the last packet and cuts that packet's data in two.

A start pulse captures the page size, the packet size and the ECC strength. These values then stay fixed until the page is finished. Each advance strobe moves the schedule to the next physical byte. For the current byte, the block reports which source feeds it, the index within that source, the offset in the logical spare area and the physical position. A one-cycle done pulse follows the last ECC byte. Surrounding logic uses these outputs to steer a byte mover between the data buffer, the spare buffer and the flash bus.

Top module: `nand_page_layout_seq`

## Requirements
- R1: After reset `out_valid` and `done` are 0 and `out_pos` is 0.
- R2: A start pulse while idle latches the configuration and shows physical byte 0. The first 4 bytes have source META (code 1), index 0..3 and spare offset 6..9.
- R3: Data bytes (source code 0) carry data-buffer indices that rise by one per byte from 0. Each non-final packet supplies exactly packet-size data bytes, and the reported spare offset of a data byte is 0.
- R4: Each packet's data is followed by ceil(strength*15/8) ECC bytes (source code 2). The ECC index runs on without a gap across packets, and the spare offset of an ECC byte is 10 plus its index.
- R5: Physical position equal to the page size starts 6 marker bytes (source code 3), with index 0..5 and spare offset 0..5.
- R6: The last packet's data fills the bytes before the marker window and resumes after it. That packet's ECC bytes come last. The configuration must place the page-size offset inside the last packet's data.
- R7: The schedule moves by exactly one physical byte per advance strobe. With no strobe, every output holds its value, and `out_pos` counts physical bytes from 0.
- R8: The strobe on the final ECC byte makes `done` high for one cycle, with `out_valid` low. The block is idle on the following cycle.
- R9: Advance strobes while idle, or in the done cycle, change no output.
- R10: Start pulses while a page is in progress are ignored. Configuration inputs are sampled only at an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a page (accepted only when idle) |
| adv | input | 1 | Move to the next physical byte |
| cfg_page_bytes | input | ADDR_W | Data page size in bytes |
| cfg_pkt_bytes | input | ADDR_W | Bytes per ECC packet |
| cfg_strength | input | STR_W | Correctable bits per packet, at least 1 |
| out_valid | output | 1 | A physical byte is being described |
| out_src | output | 2 | 0 data, 1 metadata, 2 ECC, 3 marker |
| out_idx | output | ADDR_W | Index within the selected source |
| out_spare_idx | output | ADDR_W | Offset in logical spare area (0 for data) |
| out_pos | output | ADDR_W+1 | Physical byte position |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
A wrong field counter shows up at the ports at the very next field boundary. It appears as a source change one byte early or late, and from that cycle every later position is offset. A bad data or ECC index is visible on the first byte after the corruption. A mis-placed marker shows as a marker byte whose position differs from the page size, or as data at that position. The reference model compares every output on every cycle, so any such slip is reported within one clock of its first visible effect.

// File: rtl/nand_lay_pkg.sv
package nand_lay_pkg;
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_META = 2'd1,
    SRC_ECC  = 2'd2,
    SRC_BBM  = 2'd3
  } src_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_META, ST_DATA, ST_ECC, ST_PRE, ST_BBM, ST_POST, ST_LECC, ST_DONE
  } st_e;

  localparam int META_LEN = 4;
  localparam int BBM_LEN  = 6;
  localparam int GF_ORDER = 15;
endpackage

// File: rtl/nand_lay_geom.sv
module nand_lay_geom import nand_lay_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int STR_W  = 6,
  localparam int ECC_W = STR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] cfg_page,
  input  logic [ADDR_W-1:0] cfg_pkt,
  input  logic [STR_W-1:0]  cfg_str,
  output logic [ADDR_W-1:0] page_q,
  output logic [ADDR_W-1:0] pkt_q,
  output logic [ECC_W-1:0]  eccb_q
);
  localparam int PW = STR_W + 5;

  // ECC bytes = ceil(strength * field order / 8); order 15 folds to a shift and subtract
  logic [PW-1:0] prod;
  always_comb begin
    prod = (PW'(cfg_str) << 4) - PW'(cfg_str) + PW'(7);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      pkt_q  <= '0;
      eccb_q <= '0;
    end else if (load) begin
      page_q <= cfg_page;
      pkt_q  <= cfg_pkt;
      eccb_q <= prod[PW-1:3];
    end
  end
endmodule

// File: rtl/nand_lay_fsm.sv
module nand_lay_fsm import nand_lay_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int ECC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  logic [ADDR_W-1:0] page_q,
  input  logic [ADDR_W-1:0] pkt_q,
  input  logic [ECC_W-1:0]  eccb_q,
  output logic              load,
  output logic              valid,
  output logic [1:0]        src,
  output logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] spare,
  output logic [ADDR_W:0]   pos,
  output logic              done
);
  st_e               st;
  logic [ADDR_W-1:0] cnt, didx, eidx;
  logic              last_pkt, ecc_end, pre_end, post_end;

  always_comb begin
    load     = (st == ST_IDLE) && start;
    last_pkt = ({1'b0, didx} + {1'b0, pkt_q}) >= {1'b0, page_q};
    ecc_end  = cnt == (ADDR_W'(eccb_q) - 1'b1);
    pre_end  = (pos + 1'b1) == {1'b0, page_q};
    post_end = (didx + 1'b1) == page_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      didx <= '0;
      eidx <= '0;
      pos  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_META;
          cnt  <= '0;
          didx <= '0;
          eidx <= '0;
          pos  <= '0;
        end
        ST_DONE: st <= ST_IDLE;
        default: if (adv) begin
          pos <= pos + 1'b1;
          case (st)
            ST_META: begin
              if (cnt == ADDR_W'(META_LEN - 1)) begin
                cnt <= '0;
                st  <= last_pkt ? ST_PRE : ST_DATA;
              end else cnt <= cnt + 1'b1;
            end
            ST_DATA: begin
              didx <= didx + 1'b1;
              if (cnt == pkt_q - 1'b1) begin
                cnt <= '0;
                st  <= ST_ECC;
              end else cnt <= cnt + 1'b1;
            end
            ST_ECC: begin
              eidx <= eidx + 1'b1;
              if (ecc_end) begin
                cnt <= '0;
                st  <= last_pkt ? ST_PRE : ST_DATA;
              end else cnt <= cnt + 1'b1;
            end
            ST_PRE: begin
              didx <= didx + 1'b1;
              if (pre_end) begin
                cnt <= '0;
                st  <= ST_BBM;
              end
            end
            ST_BBM: begin
              if (cnt == ADDR_W'(BBM_LEN - 1)) begin
                cnt <= '0;
                st  <= ST_POST;
              end else cnt <= cnt + 1'b1;
            end
            ST_POST: begin
              didx <= didx + 1'b1;
              if (post_end) begin
                cnt <= '0;
                st  <= ST_LECC;
              end
            end
            ST_LECC: begin
              eidx <= eidx + 1'b1;
              if (ecc_end) st <= ST_DONE;
              else cnt <= cnt + 1'b1;
            end
            default: st <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    valid = (st != ST_IDLE) && (st != ST_DONE);
    done  = (st == ST_DONE);
    src   = SRC_DATA;
    idx   = '0;
    spare = '0;
    case (st)
      ST_META: begin
        src   = SRC_META;
        idx   = cnt;
        spare = ADDR_W'(BBM_LEN) + cnt;
      end
      ST_DATA, ST_PRE, ST_POST: idx = didx;
      ST_ECC, ST_LECC: begin
        src   = SRC_ECC;
        idx   = eidx;
        spare = ADDR_W'(BBM_LEN + META_LEN) + eidx;
      end
      ST_BBM: begin
        src   = SRC_BBM;
        idx   = cnt;
        spare = cnt;
      end
      default: ;
    endcase
  end

  a_r7_hold_without_adv: assert property (@(posedge clk) disable iff (rst)
    valid && !adv |=> $stable(pos) && $stable(src) && $stable(idx));
  a_r7_one_step: assert property (@(posedge clk) disable iff (rst)
    valid && adv |=> done || (pos == $past(pos) + 1'b1));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !valid);
  a_r8_done_not_valid: assert property (@(posedge clk) disable iff (rst)
    done |-> !valid);
  a_r5_marker_at_page: assert property (@(posedge clk) disable iff (rst)
    valid && (src == SRC_BBM) && (idx == '0) |-> pos == {1'b0, page_q});
  a_r3_data_in_page: assert property (@(posedge clk) disable iff (rst)
    valid && (src == SRC_DATA) |-> idx < page_q);
  a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
    !valid && !done && !start |=> !valid);
endmodule

// File: rtl/nand_page_layout_seq.sv
module nand_page_layout_seq import nand_lay_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  logic [ADDR_W-1:0] cfg_page_bytes,
  input  logic [ADDR_W-1:0] cfg_pkt_bytes,
  input  logic [STR_W-1:0]  cfg_strength,
  output logic              out_valid,
  output logic [1:0]        out_src,
  output logic [ADDR_W-1:0] out_idx,
  output logic [ADDR_W-1:0] out_spare_idx,
  output logic [ADDR_W:0]   out_pos,
  output logic              done
);
  localparam int ECC_W = STR_W + 2;

  logic              load;
  logic [ADDR_W-1:0] page_q, pkt_q;
  logic [ECC_W-1:0]  eccb_q;

  nand_lay_geom #(.ADDR_W(ADDR_W), .STR_W(STR_W)) u_geom (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .cfg_page (cfg_page_bytes),
    .cfg_pkt  (cfg_pkt_bytes),
    .cfg_str  (cfg_strength),
    .page_q   (page_q),
    .pkt_q    (pkt_q),
    .eccb_q   (eccb_q)
  );

  nand_lay_fsm #(.ADDR_W(ADDR_W), .ECC_W(ECC_W)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .adv    (adv),
    .page_q (page_q),
    .pkt_q  (pkt_q),
    .eccb_q (eccb_q),
    .load   (load),
    .valid  (out_valid),
    .src    (out_src),
    .idx    (out_idx),
    .spare  (out_spare_idx),
    .pos    (out_pos),
    .done   (done)
  );
endmodule

// File: tb/nand_page_layout_seq_test.sv
`timescale 1ns/1ps
module nand_page_layout_seq_test;
  localparam int ADDR_W = 16;
  localparam int STR_W  = 6;

  logic clk = 0;
  logic rst = 1;
  logic start = 0, adv = 0;
  logic [ADDR_W-1:0] cfg_page_bytes = '0, cfg_pkt_bytes = '0;
  logic [STR_W-1:0]  cfg_strength = '0;
  logic out_valid, done;
  logic [1:0] out_src;
  logic [ADDR_W-1:0] out_idx, out_spare_idx;
  logic [ADDR_W:0] out_pos;

  always #2 clk = ~clk;

  nand_page_layout_seq #(.ADDR_W(ADDR_W), .STR_W(STR_W)) uut (
    .clk(clk), .rst(rst), .start(start), .adv(adv),
    .cfg_page_bytes(cfg_page_bytes), .cfg_pkt_bytes(cfg_pkt_bytes),
    .cfg_strength(cfg_strength),
    .out_valid(out_valid), .out_src(out_src), .out_idx(out_idx),
    .out_spare_idx(out_spare_idx), .out_pos(out_pos), .done(done)
  );

  int nchk = 0, nfail = 0, cycles = 0, ndone = 0;

  // reference schedule: source, index, spare offset, requirement tag
  int q_src[$], q_idx[$], q_sp[$], q_tag[$];
  int m_k = 0;
  bit m_busy = 0, m_done = 0;

  function automatic void push(int s, int i, int sp, int t);
    q_src.push_back(s); q_idx.push_back(i); q_sp.push_back(sp); q_tag.push_back(t);
  endfunction

  function automatic void build(int page, int pkt, int str);
    int ecc, pos, d, e, rem;
    q_src.delete(); q_idx.delete(); q_sp.delete(); q_tag.delete();
    ecc = (str * 15 + 7) / 8;
    for (int m = 0; m < 4; m++) push(1, m, 6 + m, 2);   // R2 metadata
    pos = 4; d = 0; e = 0;
    rem = page - pos;
    while (rem > pkt) begin
      for (int j = 0; j < pkt; j++) begin push(0, d, 0, 3); d++; end   // R3
      for (int j = 0; j < ecc; j++) begin push(2, e, 10 + e, 4); e++; end // R4
      pos += pkt + ecc;
      rem = page - pos;
    end
    for (int j = 0; j < rem; j++) begin push(0, d, 0, 3); d++; end
    for (int b = 0; b < 6; b++) push(3, b, b, 5);                      // R5
    for (int j = 0; j < pkt - rem; j++) begin push(0, d, 0, 6); d++; end // R6
    for (int j = 0; j < ecc; j++) begin push(2, e, 10 + e, 6); e++; end
  endfunction

  always @(posedge clk) begin
    bit pd;
    if (rst) begin
      m_busy = 0; m_done = 0; m_k = 0;
    end else begin
      pd = m_done;
      m_done = 0;
      if (m_busy) begin
        if (adv) begin
          if (m_k == q_src.size() - 1) begin m_busy = 0; m_done = 1; end
          else m_k++;
        end
      end else if (!pd && start) begin
        build(int'(cfg_page_bytes), int'(cfg_pkt_bytes), int'(cfg_strength));
        m_busy = 1; m_k = 0;
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    nchk++;
    if (out_valid !== m_busy) begin
      nfail++; $display("FAIL R7 valid act=%0d exp=%0d k=%0d", out_valid, m_busy, m_k);
    end else if (done !== m_done) begin
      nfail++; $display("FAIL R8 done act=%0d exp=%0d", done, m_done);
    end else if (m_busy) begin
      if (int'(out_src) != q_src[m_k] || int'(out_idx) != q_idx[m_k] ||
          int'(out_spare_idx) != q_sp[m_k]) begin
        nfail++;
        $display("FAIL R%0d pos %0d src/idx/spare act=%0d/%0d/%0d exp=%0d/%0d/%0d",
                 q_tag[m_k], m_k, out_src, out_idx, out_spare_idx,
                 q_src[m_k], q_idx[m_k], q_sp[m_k]);
      end else if (int'(out_pos) != m_k) begin
        nfail++; $display("FAIL R7 pos act=%0d exp=%0d", out_pos, m_k);
      end
    end
    if (done) ndone++;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(int page, int pkt, int str, bit gaps, bit disturb);
    int cyc = 0;
    @(negedge clk);
    cfg_page_bytes = ADDR_W'(page); cfg_pkt_bytes = ADDR_W'(pkt);
    cfg_strength = STR_W'(str); start = 1;
    @(negedge clk);
    start = 0;
    // R2 first byte is metadata index 0, spare offset 6
    chk(out_valid && out_src == 2'd1 && out_idx == 0 && out_spare_idx == 6,
        "R2 first byte", int'(out_src), 1);
    while (m_busy && cyc < 5000) begin
      adv = gaps ? (cyc % 3 != 2) : 1'b1;
      if (disturb && cyc == 10) begin
        start = 1;   // R10 ignored while busy
        cfg_page_bytes = 16'd999; cfg_pkt_bytes = 16'd3; cfg_strength = 6'd60;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    adv = 0; start = 0;
    chk(!m_busy, "R8 page finished", m_busy, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0 && done == 0 && out_pos == 0, "R1 reset", out_valid, 0);
    rst = 0;
    // R9 strobes while idle
    adv = 1;
    repeat (3) @(negedge clk);
    adv = 0;
    chk(out_valid == 0 && out_pos == 0 && done == 0, "R9 idle adv", int'(out_pos), 0);
    run(64, 32, 4, 0, 0);     // two packets
    run(128, 32, 2, 1, 0);    // four packets, gapped strobes (R7)
    run(32, 32, 1, 0, 0);     // single packet split straight after metadata (R6)
    run(512, 128, 8, 1, 1);   // R10 disturb mid-page
    // R8 one done pulse per page
    chk(ndone == 4, "R8 done count", ndone, 4);
    // R9 strobes after done
    adv = 1;
    repeat (2) @(negedge clk);
    adv = 0;
    chk(out_valid == 0 && done == 0, "R9 adv after done", out_valid, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule